// File: doc/BRIEF.md
# Video Gate Array Write-Port Register File

This block is the write side of a home-computer video gate array. It watches an 8-bit-data, 16-bit-address I/O write bus. When a write strobe arrives with an address whose top two bits are `01`, the top two data bits are taken as a command. The lower bits are stored into one of four kinds of state:

- a latched pen index;
- the palette colour for that pen;
- the screen mode and three control flags;
- a memory-paging byte.

Video logic further down reads the palette through a combinational port addressed by pen. It also reads the mode, flags and paging value as plain register outputs. A one-cycle strobe marks every change of screen mode, so that the pixel pipeline can resynchronise.

Writes are never refused. The block applies no back-pressure: every qualified write is absorbed on the clock edge where it is presented. For that reason the bus side is a plain strobe and not a valid/ready pair. The palette read port is likewise free of any handshake.

Top module: `video_ga_wrport`

## Requirements
- R1: A write whose address bits 15:14 are anything other than binary 01 leaves the pen latch, palette, mode, flags and paging value unchanged.
- R2: While `io_wr` is low, no state changes, whatever the address and data.
- R3: A qualified write with data bits 7:6 = 00 latches data bits 4:0 as the current pen. The latched pen is visible only through the target of later colour writes.
- R4: A qualified write with data bits 7:6 = 01 stores data bits 4:0 into the palette entry of the latched pen, and no other entry changes.
- R5: A latched pen of 16 or more addresses entry 16, the border, for colour writes. A `rd_pen` of 16 or more likewise reads entry 16.
- R6: A qualified write with data bits 7:6 = 10 sets `mode` to data bits 1:0 and `flags` to data bits 4:2.
- R7: A qualified write with data bits 7:6 = 11 sets `paging` to data bits 5:0, and leaves the palette, mode and flags unchanged.
- R8: While reset is asserted, and directly after it, the mode, flags, paging, pen latch and all 17 palette entries read zero, and `mode_chg` is low.
- R9: `mode_chg` is high for exactly the one cycle after an edge at which a mode command changed `mode`. It stays low when the mode command rewrites the same mode or changes only the flags.
- R10: State written at a clock edge is visible on the outputs straight after that edge, and `rd_colour` follows `rd_pen` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| io_data | input | 8 | I/O write data; bits 7:6 carry the command |
| rd_pen | input | 5 | Pen index for the palette read port |
| rd_colour | output | 5 | Palette colour of `rd_pen` (entry 16 for pens 16 and above) |
| mode | output | 2 | Current screen mode |
| flags | output | 3 | Current control flags |
| paging | output | 6 | Current memory-paging setting |
| mode_chg | output | 1 | One-cycle pulse after the screen mode changes |

## Verification
The pen latch is the only state with no direct output. If it held a wrong value, the error would show at the ports only at the next colour write. That write would land in the wrong palette entry, and the wrong entry would read back on `rd_colour` at once once `rd_pen` points at it. To catch this, the bench sweeps `rd_pen` every cycle. It compares the palette against a behavioural model on every clock, so a misplaced entry is reported within one full sweep of 32 cycles. A wrongly decoded command or address shows on `mode`, `flags` or `paging` in the cycle straight after the write. A missed or doubled mode pulse shows on `mode_chg` in that same cycle.

// File: rtl/vga_wr_pkg.sv
package vga_wr_pkg;
  typedef enum logic [1:0] {
    CMD_PEN  = 2'b00,
    CMD_INK  = 2'b01,
    CMD_MODE = 2'b10,
    CMD_PAGE = 2'b11
  } ga_cmd_e;

  localparam int CMD_HI    = 7;
  localparam int CMD_LO    = 6;
  localparam int FIELD5_HI = 4;
  localparam int MODE_HI   = 1;
  localparam int FLAG_HI   = 4;
  localparam int FLAG_LO   = 2;
  localparam int PAGE_HI   = 5;
endpackage

// File: rtl/vga_wr_decode.sv
module vga_wr_decode
  import vga_wr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SEL_PAT  = 1
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_data,
  output logic              pen_we,
  output logic              ink_we,
  output logic              mode_we,
  output logic              page_we
);
  localparam logic [1:0] SEL = 2'(SEL_PAT);

  logic    hit;
  ga_cmd_e cmd;

  always_comb begin
    hit     = io_wr && (io_addr[ADDR_W-1:ADDR_W-2] == SEL);
    cmd     = ga_cmd_e'(io_data[CMD_HI:CMD_LO]);
    pen_we  = 1'b0;
    ink_we  = 1'b0;
    mode_we = 1'b0;
    page_we = 1'b0;
    if (hit) begin
      unique case (cmd)
        CMD_PEN:  pen_we  = 1'b1;
        CMD_INK:  ink_we  = 1'b1;
        CMD_MODE: mode_we = 1'b1;
        CMD_PAGE: page_we = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/vga_wr_palette.sv
module vga_wr_palette #(
  parameter int NUM_PENS = 16,
  parameter int PEN_W    = 5,
  parameter int COLOUR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pen_we,
  input  logic                ink_we,
  input  logic [PEN_W-1:0]    pen_in,
  input  logic [COLOUR_W-1:0] ink_in,
  input  logic [PEN_W-1:0]    rd_pen,
  output logic [COLOUR_W-1:0] rd_colour
);
  localparam int ENTRIES = NUM_PENS + 1;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam logic [PEN_W-1:0] BORDER_PEN = PEN_W'(NUM_PENS);
  localparam logic [IDX_W-1:0] BORDER_IDX = IDX_W'(NUM_PENS);

  logic [PEN_W-1:0]    pen_q;
  logic [IDX_W-1:0]    wr_idx;
  logic [IDX_W-1:0]    rd_idx;
  logic [COLOUR_W-1:0] entry_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n)      pen_q <= '0;
    else if (pen_we) pen_q <= pen_in;
  end

  always_comb begin
    wr_idx = (pen_q  >= BORDER_PEN) ? BORDER_IDX : IDX_W'(pen_q);
    rd_idx = (rd_pen >= BORDER_PEN) ? BORDER_IDX : IDX_W'(rd_pen);
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q[i] <= '0;
      else if (ink_we && (wr_idx == IDX_W'(i)))
        entry_q[i] <= ink_in;
    end
  end

  always_comb begin
    rd_colour = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rd_idx == IDX_W'(i)) rd_colour = entry_q[i];
  end
endmodule

// File: rtl/vga_wr_ctrl.sv
module vga_wr_ctrl #(
  parameter int MODE_W = 2,
  parameter int FLAG_W = 3,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              page_we,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic [MODE_W-1:0] mode,
  output logic [FLAG_W-1:0] flags,
  output logic [PAGE_W-1:0] paging,
  output logic              mode_chg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      flags    <= '0;
      paging   <= '0;
      mode_chg <= 1'b0;
    end else begin
      mode_chg <= mode_we && (mode_in != mode);
      if (mode_we) begin
        mode  <= mode_in;
        flags <= flag_in;
      end
      if (page_we) paging <= page_in;
    end
  end
endmodule

// File: rtl/video_ga_wrport.sv
module video_ga_wrport
  import vga_wr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_PENS = 16,
  parameter int COLOUR_W = 5,
  parameter int MODE_W   = 2,
  parameter int FLAG_W   = 3,
  parameter int PAGE_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_wr,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [DATA_W-1:0]   io_data,
  input  logic [4:0]          rd_pen,
  output logic [COLOUR_W-1:0] rd_colour,
  output logic [MODE_W-1:0]   mode,
  output logic [FLAG_W-1:0]   flags,
  output logic [PAGE_W-1:0]   paging,
  output logic                mode_chg
);
  localparam int PEN_W = 5;

  logic pen_we, ink_we, mode_we, page_we;

  vga_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_PAT(1)) u_dec (
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_data (io_data),
    .pen_we  (pen_we),
    .ink_we  (ink_we),
    .mode_we (mode_we),
    .page_we (page_we)
  );

  vga_wr_palette #(.NUM_PENS(NUM_PENS), .PEN_W(PEN_W), .COLOUR_W(COLOUR_W)) u_pal (
    .clk       (clk),
    .rst_n     (rst_n),
    .pen_we    (pen_we),
    .ink_we    (ink_we),
    .pen_in    (io_data[PEN_W-1:0]),
    .ink_in    (io_data[COLOUR_W-1:0]),
    .rd_pen    (rd_pen),
    .rd_colour (rd_colour)
  );

  vga_wr_ctrl #(.MODE_W(MODE_W), .FLAG_W(FLAG_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_we  (mode_we),
    .page_we  (page_we),
    .mode_in  (io_data[MODE_W-1:0]),
    .flag_in  (io_data[FLAG_LO +: FLAG_W]),
    .page_in  (io_data[PAGE_W-1:0]),
    .mode     (mode),
    .flags    (flags),
    .paging   (paging),
    .mode_chg (mode_chg)
  );
endmodule

// File: rtl/video_ga_wrport_chk.sv
module video_ga_wrport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [7:0]  io_data,
  input logic [1:0]  mode,
  input logic [2:0]  flags,
  input logic [5:0]  paging,
  input logic        mode_chg
);
  logic sel;
  assign sel = io_wr && (io_addr[15:14] == 2'b01);

  // R1 / R2: no qualified write, so the control registers hold their values
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(mode) && $stable(flags) && $stable(paging)));

  // R6: a mode command loads the mode and the flags
  p_mode_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && io_data[7:6] == 2'b10) |=>
      (mode == $past(io_data[1:0]) && flags == $past(io_data[4:2])));

  // R7: a paging command loads paging and leaves the mode alone
  p_page_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && io_data[7:6] == 2'b11) |=>
      (paging == $past(io_data[5:0]) && $stable(mode) && $stable(flags)));

  // R9: a pulse only accompanies a real change of mode
  p_chg_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (mode != $past(mode)));

  // R9: every change of mode is accompanied by a pulse
  p_chg_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> mode_chg);
endmodule

bind video_ga_wrport video_ga_wrport_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_wr    (io_wr),
  .io_addr  (io_addr),
  .io_data  (io_data),
  .mode     (mode),
  .flags    (flags),
  .paging   (paging),
  .mode_chg (mode_chg)
);

// File: tb/video_ga_wrport_tb.sv
`timescale 1ns/1ps
module video_ga_wrport_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic [4:0]  rd_pen = '0;
  logic [4:0]  rd_colour;
  logic [1:0]  mode;
  logic [2:0]  flags;
  logic [5:0]  paging;
  logic        mode_chg;

  always #5 clk = ~clk;

  video_ga_wrport u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .rd_pen(rd_pen), .rd_colour(rd_colour),
    .mode(mode), .flags(flags), .paging(paging), .mode_chg(mode_chg)
  );

  // behavioural reference
  int m_pal [17];
  int m_pen, m_mode, m_flags, m_page;
  bit m_chg;
  int checks = 0;
  int errors = 0;
  string req = "R8";
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pal[k]) m_pal[k] = 0;
      m_pen = 0; m_mode = 0; m_flags = 0; m_page = 0; m_chg = 0;
    end else begin
      m_chg = 0;
      if (io_wr && io_addr[15:14] == 2'b01) begin
        case (int'(io_data) / 64)
          0: m_pen = int'(io_data) % 32;
          1: m_pal[(m_pen > 16) ? 16 : m_pen] = int'(io_data) % 32;
          2: begin
               m_chg   = (int'(io_data) % 4) != m_mode;
               m_mode  = int'(io_data) % 4;
               m_flags = (int'(io_data) / 4) % 8;
             end
          default: m_page = int'(io_data) % 64;
        endcase
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge (R10), then move the read pen on
  always @(negedge clk) begin
    if (!finished) begin
      chk("mode", int'(mode), m_mode);
      chk("flags", int'(flags), m_flags);
      chk("paging", int'(paging), m_page);
      chk("mode_chg", int'(mode_chg), int'(m_chg));
      chk("rd_colour", int'(rd_colour), m_pal[(rd_pen > 16) ? 16 : int'(rd_pen)]);
      rd_pen <= rd_pen + 5'd1;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic s = 1'b1);
    @(negedge clk);
    io_wr = s; io_addr = a; io_data = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R8: reset state, held for a few cycles and just after release
    req = "R8";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(34);

    // R3 R4: latch each pen then write its colour
    req = "R4";
    for (int p = 0; p < 16; p++) begin
      wr(16'h7F00, 8'(p));
      wr(16'h7F00, 8'h40 | 8'((p * 7 + 3) % 32));
    end
    idle(34);
    req = "R3";
    wr(16'h4000, 8'h05);
    wr(16'h4000, 8'h5F);
    wr(16'h4000, 8'h4A);
    idle(34);

    // R5: pens 16 and above hit the border entry
    req = "R5";
    wr(16'h4123, 8'h10); wr(16'h4123, 8'h51);
    wr(16'h4123, 8'h1F); wr(16'h4123, 8'h4C);
    wr(16'h4123, 8'h14); wr(16'h4123, 8'h57);
    idle(34);

    // R6 R9: mode and flag writes
    req = "R6";
    wr(16'h7F00, 8'h9D);
    wr(16'h7F00, 8'h81);
    wr(16'h7F00, 8'h8E);
    req = "R9";
    wr(16'h7F00, 8'h92);
    wr(16'h7F00, 8'h9E);
    @(negedge clk); io_wr = 1'b1; io_addr = 16'h7F00; io_data = 8'h80;
    @(negedge clk); io_data = 8'h83;
    @(negedge clk); io_data = 8'h83;
    @(negedge clk); io_wr = 1'b0;
    idle(4);

    // R7: paging leaves palette and mode intact
    req = "R7";
    wr(16'h7F00, 8'hC5); wr(16'h7F00, 8'hFF); wr(16'h4000, 8'hEA);
    idle(34);

    // R1: addresses outside the gate-array window
    req = "R1";
    wr(16'h0000, 8'h9F); wr(16'h8000, 8'hC3); wr(16'hC000, 8'h01);
    wr(16'hBFFF, 8'h1E); wr(16'h3FFF, 8'h5B); wr(16'hFFFF, 8'h82);
    idle(34);

    // R2: strobe low, matching address
    req = "R2";
    wr(16'h7F00, 8'h81, 1'b0); wr(16'h7F00, 8'h5F, 1'b0);
    wr(16'h7F00, 8'hD1, 1'b0); wr(16'h7F00, 8'h1F, 1'b0);
    idle(34);

    // R10: mixed back-to-back traffic
    req = "R10";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      io_wr   = ((i * 13) % 5) != 0;
      io_addr = 16'((i * 40503 + 7) % 65536);
      if (i % 3 == 0) io_addr[15:14] = 2'b01;
      io_data = 8'((i * 97 + 11) % 256);
    end
    @(negedge clk); io_wr = 1'b0;
    idle(34);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule